// File: doc/BRIEF.md
# Three-Wire Serial Register Access Port

This block is the slave end of a three-wire serial link through which a host processor reads and writes the 8-bit control registers of a larger chip. The host drives an active-low select, a slow serial clock and one shared data line. The block samples all three with the fast on-chip clock, assembles each 16-clock frame, and turns a completed frame into either a one-cycle write strobe or a one-cycle read request toward the register file that sits beside it.

For a read, the port fetches the register value and sends it back on the same data line. It takes over the line after the address phase and gives the line back at the end of the frame. Writes may be chained under one select. A read ends the useful life of that select, and the host must raise the select before the next access. A parameter mask lists which addresses exist. Accesses to any other address are dropped without effect.

Top module: `tri_wire_reg_port`

## Requirements
- R1: A frame is 16 serial clocks, sampled on rising SCLK edges, most significant first: the direction bit (0 = write, 1 = read), address bits 5 down to 0, one spacer bit whose value is ignored, then data bits 7 down to 0.
- R2: A write raises `wr_stb` for exactly one clock cycle, carrying the frame's address and data, only after the 16th rising SCLK edge. After 15 edges nothing has been written.
- R3: If the select rises before the 16th rising edge, the partial write is dropped. While the select is high, no strobe, no read request and no line drive occur.
- R4: While the select stays low, any number of write frames may follow one another, and each one commits on its own 16th edge.
- R5: After the 7th rising edge of a read frame, `rd_req` pulses for one cycle with `rd_addr` set to the address. `rd_data` is taken in that same cycle. A write strobe and a read request never coincide.
- R6: On the first falling SCLK edge after the 7th rising edge, the port enables its driver and presents data bit 7. It holds that bit through the next falling edge. The following seven falling edges present bits 6 down to 0, so the host samples bits 7..0 on rising edges 9 to 16. The falling edge after rising edge 16 releases the line.
- R7: After a read frame, further SCLK activity under the same select is ignored: no strobe, no second read request, and the line stays released until the select rises.
- R8: Only addresses whose bit is set in `VALID_MASK` exist. The default mask enables addresses 1 to 11. A write to another address produces no strobe. A read of another address produces no `rd_req` and returns eight zero bits.
- R9: After reset, and within one cycle of the synchronised select going high (including in the middle of a read), the driver enable is low and the frame state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Host select, active low, asynchronous |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Data value driven by the port during reads |
| sdio_oe | output | 1 | Pad driver enable for the data line |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| rd_req | output | 1 | One-cycle register read request |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | DATA_W | Register value, sampled while rd_req is high |

## Verification
The bench targets these corner cases:
- Commit timing at the frame boundary. A design that commits one edge early writes on a 15-edge frame, and one that ignores the select loses no partial frame.
- Chained writes. A counter that does not wrap to zero after a frame would drop or misalign the second and third frames.
- The read turnaround. The bench checks when the driver turns on, that the ignored spacer slot is honoured, and that the line is released after bit 0. A mistake here shows up as shifted read data or a driver still on at the end of the frame.
- Behaviour after a read, unknown addresses, and a select that rises in mid-read. A faulty port would accept a trailing write, return stale register data instead of zeros, or keep fighting the host on the line.

// File: rtl/twp_pkg.sv
// Shared types for the three-wire register port.
// Assumes nothing beyond standard SystemVerilog packages.
package twp_pkg;

    // Frame controller states.
    typedef enum logic [2:0] {
        ST_IDLE,     // select high, nothing in progress
        ST_SHIFT,    // collecting header or write bits
        ST_RD_LOAD,  // read request out, capture register data
        ST_RD_RUN,   // shifting read data onto the line
        ST_DONE      // read finished, wait for select to rise
    } twp_state_e;

endpackage

// File: rtl/twp_sync.sv
// Two-stage synchroniser with edge detection for a vector of asynchronous
// inputs. Each bit resets to its own value from RST_VAL. Edges are found by
// comparing the synchronised sample with the one from the previous cycle.
// Assumes every input stays stable for several clk cycles between changes.
module twp_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2, s3;

        // Metastability filter and one-cycle history for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
                s3 <= RST_VAL[i];
            end else begin
                s1 <= din[i];
                s2 <= s1;
                s3 <= s2;
            end
        end

        assign lvl[i]  = s2;
        assign rise[i] = s2 & ~s3;
        assign fall[i] = ~s2 & s3;
    end

endmodule

// File: rtl/twp_addr_decode.sv
// Address existence check: an address is accepted when its bit in the mask
// is set. Purely combinational; assumes the mask covers 2**ADDR_W addresses.
module twp_addr_decode #(
    parameter int                    ADDR_W     = 6,
    parameter logic [2**ADDR_W-1:0]  VALID_MASK = '1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    // Mask lookup for the candidate address.
    always_comb hit = VALID_MASK[addr];

endmodule

// File: rtl/twp_frame_ctrl.sv
// Frame controller for the three-wire port. Consumes synchronised select
// and SCLK edge pulses, assembles the 16-bit frame, raises write strobes and
// read requests, and shifts read data out on falling edges.
// Assumes the select level and edge pulses come from twp_sync, and that
// successive SCLK edges are several clk cycles apart.
module twp_frame_ctrl
    import twp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi_s,
    output logic [ADDR_W-1:0] wr_cand,
    output logic [ADDR_W-1:0] rd_cand,
    input  logic              wr_hit,
    input  logic              rd_hit,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int HDR_W   = 1 + ADDR_W;
    localparam int FRAME_W = HDR_W + 1 + DATA_W;
    localparam int SH_W    = FRAME_W - 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    localparam logic [CNT_W-1:0] C_HDR_LAST = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] C_HDR      = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] C_SHIFT_LO = CNT_W'(HDR_W + 2);
    localparam logic [CNT_W-1:0] C_LAST     = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] C_FRAME    = CNT_W'(FRAME_W);

    twp_state_e        state;
    logic [SH_W-1:0]   shreg;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] obuf;
    logic              rd_hit_q;

    // Candidate addresses as they stand on the edge that completes them.
    assign rd_cand = {shreg[ADDR_W-2:0], sdi_s};
    assign wr_cand = shreg[SH_W-2 -: ADDR_W];

    // Frame sequencing, commit pulses and read data shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            cnt      <= '0;
            obuf     <= '0;
            rd_hit_q <= 1'b0;
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            rd_req   <= 1'b0;
            rd_addr  <= '0;
            sdo      <= 1'b0;
            sdo_oe   <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_req <= 1'b0;
            if (cs_n_s) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                sdo_oe <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        state <= ST_SHIFT;
                        cnt   <= '0;
                    end
                    ST_SHIFT: begin
                        if (sck_rise) begin
                            shreg <= {shreg[SH_W-2:0], sdi_s};
                            if (cnt == C_HDR_LAST && shreg[HDR_W-2]) begin
                                rd_addr  <= rd_cand;
                                rd_req   <= rd_hit;
                                rd_hit_q <= rd_hit;
                                cnt      <= C_HDR;
                                state    <= ST_RD_LOAD;
                            end else if (cnt == C_LAST) begin
                                wr_addr <= wr_cand;
                                wr_data <= {shreg[DATA_W-2:0], sdi_s};
                                wr_stb  <= wr_hit;
                                cnt     <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_LOAD: begin
                        obuf  <= rd_hit_q ? rd_data : '0;
                        state <= ST_RD_RUN;
                    end
                    ST_RD_RUN: begin
                        if (sck_rise && cnt != C_FRAME) begin
                            cnt <= cnt + 1'b1;
                        end
                        if (sck_fall) begin
                            if (cnt == C_HDR) begin
                                sdo_oe <= 1'b1;
                                sdo    <= obuf[DATA_W-1];
                                obuf   <= {obuf[DATA_W-2:0], 1'b0};
                            end else if (cnt >= C_SHIFT_LO && cnt <= C_LAST) begin
                                sdo    <= obuf[DATA_W-1];
                                obuf   <= {obuf[DATA_W-2:0], 1'b0};
                            end else if (cnt == C_FRAME) begin
                                sdo_oe <= 1'b0;
                                state  <= ST_DONE;
                            end
                        end
                    end
                    default: begin
                        sdo_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/tri_wire_reg_port.sv
// Top of the three-wire register port: synchroniser, frame controller and
// address decoders. The pad buffer is outside; sdio_oe selects its direction.
// Assumes clk runs at least ten times faster than SCLK.
module tri_wire_reg_port #(
    parameter int                   ADDR_W     = 6,
    parameter int                   DATA_W     = 8,
    parameter logic [2**ADDR_W-1:0] VALID_MASK = (2**ADDR_W)'(64'h0000_0000_0000_0FFE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data
);

    logic [2:0]        s_lvl, s_rise, s_fall;
    logic              cs_n_s, sck_rise, sck_fall, sdi_s;
    logic [ADDR_W-1:0] wr_cand, rd_cand;
    logic              wr_hit, rd_hit;

    // Bit order {select, clock, data}; select resets inactive (high).
    twp_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n_i, sclk_i, sdio_i}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    assign cs_n_s   = s_lvl[2];
    assign sck_rise = s_rise[1];
    assign sck_fall = s_fall[1];
    assign sdi_s    = s_lvl[0];

    twp_addr_decode #(.ADDR_W(ADDR_W), .VALID_MASK(VALID_MASK)) u_dec_wr (
        .addr(wr_cand),
        .hit (wr_hit)
    );

    twp_addr_decode #(.ADDR_W(ADDR_W), .VALID_MASK(VALID_MASK)) u_dec_rd (
        .addr(rd_cand),
        .hit (rd_hit)
    );

    twp_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (cs_n_s),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .sdi_s   (sdi_s),
        .wr_cand (wr_cand),
        .rd_cand (rd_cand),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .sdo     (sdio_o),
        .sdo_oe  (sdio_oe)
    );

endmodule

// File: rtl/twp_checker.sv
// Protocol checker for tri_wire_reg_port, attached with bind below.
// Assumes synchronous active-low reset; all properties disabled during reset.
module twp_checker #(
    parameter int                   ADDR_W     = 6,
    parameter logic [2**ADDR_W-1:0] VALID_MASK = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_s,
    input logic              sck_fall,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              sdio_oe
);

    logic [1:0] rd_seen;

    // Counts read requests issued under the current select.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) rd_seen <= '0;
        else if (rd_req && rd_seen != 2'd3) rd_seen <= rd_seen + 2'd1;
    end

    assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (!wr_stb && !rd_req));

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_req));

    assert_drive_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe) |-> $past(sck_fall));

    assert_single_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_seen == 2'd0));

    assert_wr_known_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> VALID_MASK[wr_addr]);

    assert_rd_known_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> VALID_MASK[rd_addr]);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !sdio_oe);

endmodule

bind tri_wire_reg_port twp_checker #(.ADDR_W(ADDR_W), .VALID_MASK(VALID_MASK)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_s  (cs_n_s),
    .sck_fall(sck_fall),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .sdio_oe (sdio_oe)
);

// File: tb/tri_wire_reg_port_bench.sv
// Directed bench for tri_wire_reg_port: one task per scenario.
module tri_wire_reg_port_bench;

    localparam int HP = 8;        // SCLK half period in clk cycles
    localparam int WD = 150000;   // watchdog limit in clk cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       host_d = 1'b0;
    logic       host_en = 1'b1;
    logic       sdio_o, sdio_oe, wr_stb, rd_req;
    logic [5:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic [7:0] regmem [0:63];
    logic       sdio_line;

    int vec = 0, err = 0, cyc = 0;
    int wr_n = 0, rd_n = 0;
    logic [5:0] last_wa, last_ra;
    logic [7:0] last_wd;

    always #2 clk = ~clk;

    assign sdio_line = sdio_oe ? sdio_o : (host_en ? host_d : 1'b0);
    assign rd_data   = regmem[rd_addr];

    tri_wire_reg_port u_tri_wire_reg_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n_i (cs_n),
        .sclk_i (sclk),
        .sdio_i (sdio_line),
        .sdio_o (sdio_o),
        .sdio_oe(sdio_oe),
        .wr_stb (wr_stb),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_req (rd_req),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    // Register file model and strobe monitor.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) regmem[i] <= 8'(i * 37) ^ 8'hC3;
        end else begin
            if (wr_stb) begin
                wr_n++; last_wa = wr_addr; last_wd = wr_data;
                regmem[wr_addr] <= wr_data;
            end
            if (rd_req) begin
                rd_n++; last_ra = rd_addr;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == WD) begin
            err++;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WD);
            $display("== %0d vectors applied, %0d miscompares ==", vec, err);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One SCLK period: data set while low, sampled at the rising edge.
    task automatic sbit(input logic b, output logic s, output logic oe);
        host_d = b;
        wait_clk(HP);
        s = sdio_line; oe = sdio_oe;
        sclk = 1'b1;
        wait_clk(HP);
        sclk = 1'b0;
    endtask

    task automatic send(input logic [15:0] bits, input int n);
        logic s, oe;
        for (int i = 15; i > 15 - n; i--) sbit(bits[i], s, oe);
    endtask

    task automatic sel;
        wait_clk(2); cs_n = 1'b0; wait_clk(HP);
    endtask

    task automatic desel;
        wait_clk(HP); cs_n = 1'b1; wait_clk(2 * HP);
    endtask

    task automatic wframe(input logic [5:0] a, input logic [7:0] d);
        send({1'b0, a, 1'b1, d}, 16);   // spacer sent as 1, must be ignored
    endtask

    // Full read under its own select; returns data, driver state, release.
    task automatic rframe(input logic [5:0] a, output logic [7:0] d,
                          output logic oe_all, output logic oe_after);
        logic s, oe;
        sel();
        send({1'b1, a, 9'h0}, 7);
        host_en = 1'b0;
        oe_all = 1'b1;
        sbit(1'b0, s, oe);                  // spacer slot
        for (int i = 7; i >= 0; i--) begin
            sbit(1'b0, s, oe);
            d[i] = s;
            oe_all &= oe;
        end
        wait_clk(6);
        oe_after = sdio_oe;
        host_en = 1'b1;
        desel();
    endtask

    task automatic t_reset;
        chk("R9 reset oe", 32'(sdio_oe), 0);
        chk("R9 reset wr_stb", 32'(wr_stb), 0);
        chk("R9 reset rd_req", 32'(rd_req), 0);
    endtask

    task automatic t_write;
        int w0 = wr_n;
        sel(); wframe(6'd3, 8'hA5); wait_clk(HP);
        chk("R2 one strobe", 32'(wr_n - w0), 1);
        chk("R1 write addr", 32'(last_wa), 3);
        chk("R1 write data", 32'(last_wd), 32'hA5);
        desel();
    endtask

    task automatic t_partial;
        int w0 = wr_n;
        logic [7:0] d; logic oa, of;
        sel(); send({1'b0, 6'd5, 1'b0, 8'h3C}, 15); wait_clk(2 * HP);
        chk("R2 no commit at edge 15", 32'(wr_n - w0), 0);
        desel();
        chk("R3 partial dropped", 32'(wr_n - w0), 0);
        rframe(6'd5, d, oa, of);
        chk("R3 register untouched", 32'(d), 32'(8'(5 * 37) ^ 8'hC3));
    endtask

    task automatic t_chain;
        int w0 = wr_n;
        logic [7:0] d; logic oa, of;
        sel(); wframe(6'd1, 8'h11); wframe(6'd2, 8'h22); wframe(6'd11, 8'h3C); wait_clk(HP);
        chk("R4 three commits", 32'(wr_n - w0), 3);
        chk("R4 last addr", 32'(last_wa), 11);
        desel();
        rframe(6'd2, d, oa, of);
        chk("R4 middle frame data", 32'(d), 32'h22);
    endtask

    task automatic t_read;
        int r0 = rd_n;
        logic [7:0] d; logic oa, of;
        rframe(6'd3, d, oa, of);
        chk("R5 one request", 32'(rd_n - r0), 1);
        chk("R5 read addr", 32'(last_ra), 3);
        chk("R6 read data", 32'(d), 32'hA5);
        chk("R6 driver on during data", 32'(oa), 1);
        chk("R6 released after bit 0", 32'(of), 0);
    endtask

    task automatic t_after_read;
        int w0 = wr_n, r0 = rd_n;
        logic s, oe;
        logic [7:0] d; logic oa, of;
        sel();
        send({1'b1, 6'd3, 9'h0}, 7);
        host_en = 1'b0;
        for (int i = 0; i < 9; i++) sbit(1'b0, s, oe);
        host_en = 1'b1;
        wframe(6'd3, 8'h00);
        send({1'b1, 6'd3, 9'h0}, 16);
        wait_clk(HP);
        chk("R7 trailing write ignored", 32'(wr_n - w0), 0);
        chk("R7 no second request", 32'(rd_n - r0), 1);
        chk("R7 line stays released", 32'(sdio_oe), 0);
        desel();
        rframe(6'd3, d, oa, of);
        chk("R7 register kept", 32'(d), 32'hA5);
    endtask

    task automatic t_unlisted;
        int w0 = wr_n, r0;
        logic [7:0] d; logic oa, of;
        sel(); wframe(6'd0, 8'h77); wframe(6'd40, 8'h12); wait_clk(HP);
        chk("R8 no strobe for unknown address", 32'(wr_n - w0), 0);
        desel();
        r0 = rd_n;
        rframe(6'd40, d, oa, of);
        chk("R8 no request for unknown address", 32'(rd_n - r0), 0);
        chk("R8 unknown read returns zero", 32'(d), 0);
        chk("R8 driver still used", 32'(oa), 1);
    endtask

    task automatic t_abort;
        int w0;
        logic s, oe;
        sel();
        send({1'b1, 6'd1, 9'h0}, 7);
        host_en = 1'b0;
        sbit(1'b0, s, oe);
        sbit(1'b0, s, oe);
        chk("R6 driving mid-read", 32'(sdio_oe), 1);
        cs_n = 1'b1;
        wait_clk(5);
        chk("R9 release on select high", 32'(sdio_oe), 0);
        host_en = 1'b1;
        wait_clk(2 * HP);
        w0 = wr_n;
        sel(); wframe(6'd2, 8'h99); wait_clk(HP);
        chk("R9 clean restart after abort", 32'(last_wd), 32'h99);
        chk("R9 restart commit count", 32'(wr_n - w0), 1);
        desel();
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_write();
        t_partial();
        t_chain();
        t_read();
        t_after_read();
        t_unlisted();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end

endmodule